// File: doc/BRIEF.md
# Phase-Frequency Detector with Power Sequencing

This block sits between the two divider chains of a frequency synthesizer and an external charge pump. It watches single-cycle events from the reference divider and from the feedback divider. For each comparison cycle it produces one of four pump commands: pump-up, pump-down, both at once, or high-impedance. A lead of either divider is reported for as many cycles as it lasts. When the two edges coincide, both commands pulse for exactly one cycle. This short pulse on both outputs is how the locked condition looks at the pins.

Static control inputs shape the outputs. One swaps up and down to match the sign of the oscillator's tuning slope. Another silences the pump. A diagnostic mode hands the pump pin over to the raw level of one of the dividers. A two-bit mode request, together with a chip-enable pin, drives a small power sequencer. The sequencer has four results: running, counter reset, power-down deferred until the open pump pulse closes, and immediate power-down. In every state other than running, a hold output freezes both dividers at their load point.

Top module: `pfd_pwrctl`

## Requirements
- R1: After reset the block is running: `div_hold`, `pwr_down`, `pump_up`, `pump_dn` and `pin_test_en` are 0 and `pump_hiz` is 1.
- R2: With `pol_pos`=1, a reference event raises `pump_up` on the next clock edge. It stays high until the edge after the matching feedback event. At that edge `pump_dn` joins for one cycle, and both then drop together. An event that arrives during that clearing cycle starts a new pulse.
- R3: With `pol_pos`=0, the roles of `pump_up` and `pump_dn` are exchanged relative to R2 and R5.
- R4: Reference and feedback events in the same cycle give exactly one cycle with both pump outputs high.
- R5: With `pol_pos`=1, a feedback event that leads drives `pump_dn` until the edge after the reference event arrives.
- R6: `pump_hiz` is 1 exactly when neither pump output is high and the test route is off.
- R7: With `test_mode`=0, `cp_tri`=1 holds both pump outputs low and keeps the detector cleared. Events seen in that time leave no pulse once `cp_tri` returns to 0.
- R8: With `test_mode`=1 and `cp_tri`=1, `pin_test_en` is 1, `pump_hiz` is 0 and `pin_test_lvl` follows `ref_div` when `pol_pos`=0 and `fb_div` when `pol_pos`=1. With `test_mode`=1 and `cp_tri`=0, the pin is high-impedance.
- R9: The mode request {`cnt_rst`,`pwdn`}=10 sets `div_hold` from the next edge, while `pwr_down` stays 0.
- R10: The request 01 enters power-down (`pwr_down`=`div_hold`=1) on the next edge if no pump pulse is open. If a pulse is open, the request waits until the edge where that pulse closes.
- R11: The request 11 enters power-down on the next edge even in the middle of a pulse, and silences the pump outputs.
- R12: `chip_en`=0 gives `pwr_down`=`div_hold`=1 and a high-impedance pin in the same cycle, whatever the mode bits.
- R13: Divider events during counter reset or power-down are dropped. After release to mode 00, the detector starts with no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chip_en | input | 1 | Chip enable; low forces power-down |
| ref_evt | input | 1 | One-cycle event from the reference divider |
| fb_evt | input | 1 | One-cycle event from the feedback divider |
| ref_div | input | 1 | Raw reference divider level for test routing |
| fb_div | input | 1 | Raw feedback divider level for test routing |
| pol_pos | input | 1 | 1 = positive tuning slope, 0 = inverted |
| cp_tri | input | 1 | Forces the pump to high-impedance |
| test_mode | input | 1 | Routes a divider level to the pump pin |
| cnt_rst | input | 1 | Mode request bit: counter reset |
| pwdn | input | 1 | Mode request bit: power-down |
| pump_up | output | 1 | Pump-up command |
| pump_dn | output | 1 | Pump-down command |
| pump_hiz | output | 1 | Pump pin high-impedance |
| pin_test_en | output | 1 | Pump pin driven by the test level |
| pin_test_lvl | output | 1 | Level placed on the pump pin in test mode |
| div_hold | output | 1 | Hold both dividers at their load point |
| pwr_down | output | 1 | Block is powered down |

## Verification
The assertions check rules that must hold in every cycle. The pin is never driven while powered down. Chip-enable low gives an immediate power-down. Modes 11 and 10 take effect one edge after the request. High-impedance and the two pump commands exclude each other. Only the bench's scenarios show how long pulses are and when they happen: how long a lead lasts, the single both-high cycle at lock, the swap under polarity, the deferral of synchronous power-down to the close of an open pulse, and the absence of stale pulses after reset or power-down is released.

// File: rtl/pfd_pwrctl.sv
module pfd_pwrctl (
  input  logic clk,
  input  logic rst_n,
  input  logic chip_en,
  input  logic ref_evt,
  input  logic fb_evt,
  input  logic ref_div,
  input  logic fb_div,
  input  logic pol_pos,
  input  logic cp_tri,
  input  logic test_mode,
  input  logic cnt_rst,
  input  logic pwdn,
  output logic pump_up,
  output logic pump_dn,
  output logic pump_hiz,
  output logic pin_test_en,
  output logic pin_test_lvl,
  output logic div_hold,
  output logic pwr_down
);

  typedef enum logic [1:0] {S_RUN, S_CRST, S_SPD, S_APD} pstate_t;

  pstate_t st, st_nxt;
  logic up_q, dn_q;

  wire both       = up_q & dn_q;
  wire pulse_open = (up_q | dn_q) & ~both;

  always_comb begin
    if (!chip_en || (cnt_rst && pwdn))
      st_nxt = S_APD;
    else if (cnt_rst)
      st_nxt = S_CRST;
    else if (pwdn)
      st_nxt = (st == S_RUN && pulse_open) ? S_RUN : S_SPD;
    else
      st_nxt = S_RUN;
  end

  wire det_clr = (st_nxt != S_RUN) | cp_tri | test_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_RUN;
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      st   <= st_nxt;
      up_q <= det_clr ? 1'b0 : ((up_q & ~both) | ref_evt);
      dn_q <= det_clr ? 1'b0 : ((dn_q & ~both) | fb_evt);
    end
  end

  wire running = (st == S_RUN) & chip_en;
  wire pump_on = running & ~cp_tri & ~test_mode;

  assign pwr_down     = ~chip_en | (st == S_SPD) | (st == S_APD);
  assign div_hold     = ~running;
  assign pump_up      = pump_on & (pol_pos ? up_q : dn_q);
  assign pump_dn      = pump_on & (pol_pos ? dn_q : up_q);
  assign pin_test_en  = ~pwr_down & test_mode & cp_tri;
  assign pin_test_lvl = pin_test_en & (pol_pos ? fb_div : ref_div);
  assign pump_hiz     = ~pump_up & ~pump_dn & ~pin_test_en;

endmodule

// File: rtl/pfd_pwrctl_chk.sv
module pfd_pwrctl_chk (
  input logic clk,
  input logic rst_n,
  input logic chip_en,
  input logic cp_tri,
  input logic test_mode,
  input logic cnt_rst,
  input logic pwdn,
  input logic pump_up,
  input logic pump_dn,
  input logic pump_hiz,
  input logic pin_test_en,
  input logic div_hold,
  input logic pwr_down
);

  p_down_silent_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |-> (pump_hiz && !pump_up && !pump_dn && !pin_test_en));

  p_ce_low_down_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_en |-> (pwr_down && div_hold));

  p_async_next_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_en && cnt_rst && pwdn) |=> pwr_down);

  p_crst_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_en && cnt_rst && !pwdn) |=> (div_hold && (pwr_down == !chip_en)));

  p_hiz_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pump_hiz |-> (!pump_up && !pump_dn && !pin_test_en));

  p_cptri_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_tri && !test_mode) |-> (!pump_up && !pump_dn && pump_hiz));

  p_test_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pin_test_en |-> (!pump_hiz && !pump_up && !pump_dn));

  p_down_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |-> div_hold);

endmodule

bind pfd_pwrctl pfd_pwrctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .cp_tri(cp_tri),
  .test_mode(test_mode), .cnt_rst(cnt_rst), .pwdn(pwdn),
  .pump_up(pump_up), .pump_dn(pump_dn), .pump_hiz(pump_hiz),
  .pin_test_en(pin_test_en), .div_hold(div_hold), .pwr_down(pwr_down)
);

// File: tb/pfd_pwrctl_tb.sv
module pfd_pwrctl_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chip_en = 1'b1, ref_evt = 1'b0, fb_evt = 1'b0, ref_div = 1'b0, fb_div = 1'b0;
  logic pol_pos = 1'b1, cp_tri = 1'b0, test_mode = 1'b0, cnt_rst = 1'b0, pwdn = 1'b0;
  logic pump_up, pump_dn, pump_hiz, pin_test_en, pin_test_lvl, div_hold, pwr_down;

  always #(CLK_PERIOD/2) clk = ~clk;

  pfd_pwrctl u_dut (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .ref_evt(ref_evt), .fb_evt(fb_evt),
    .ref_div(ref_div), .fb_div(fb_div), .pol_pos(pol_pos), .cp_tri(cp_tri),
    .test_mode(test_mode), .cnt_rst(cnt_rst), .pwdn(pwdn),
    .pump_up(pump_up), .pump_dn(pump_dn), .pump_hiz(pump_hiz),
    .pin_test_en(pin_test_en), .pin_test_lvl(pin_test_lvl),
    .div_hold(div_hold), .pwr_down(pwr_down)
  );

  typedef struct {
    logic [6:0] vec;
    string      tag;
  } exp_t;

  exp_t q[$];
  int nvec = 0;
  int nfail = 0;
  bit done = 1'b0;

  logic c_ce = 1'b1, c_pol = 1'b1, c_tri = 1'b0, c_test = 1'b0, c_crst = 1'b0, c_pd = 1'b0;
  logic c_rdiv = 1'b0, c_fdiv = 1'b0;
  logic e_ten = 1'b0, e_tlvl = 1'b0, e_hold = 1'b0, e_pd = 1'b0;

  task automatic step(input logic r, input logic f, input logic up, input logic dn,
                      input logic hiz, input string tag);
    exp_t it;
    @(negedge clk);
    chip_en = c_ce; pol_pos = c_pol; cp_tri = c_tri; test_mode = c_test;
    cnt_rst = c_crst; pwdn = c_pd; ref_div = c_rdiv; fb_div = c_fdiv;
    ref_evt = r; fb_evt = f;
    it.vec = {up, dn, hiz, e_ten, e_tlvl, e_hold, e_pd};
    it.tag = tag;
    q.push_back(it);
  endtask

  initial begin : monitor
    exp_t it;
    logic [6:0] act;
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        it  = q.pop_front();
        act = {pump_up, pump_dn, pump_hiz, pin_test_en, pin_test_lvl, div_hold, pwr_down};
        nvec++;
        if (act !== it.vec) begin
          nfail++;
          $display("FAIL %s: {up,dn,hiz,ten,tlvl,hold,pd} actual %b expected %b at %0t",
                   it.tag, act, it.vec, $time);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL ALL: watchdog expired, actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    step(0,0, 0,0,1, "R1");
    step(0,0, 0,0,1, "R6");

    // R2 reference leads
    step(1,0, 1,0,0, "R2");
    step(0,0, 1,0,0, "R2");
    step(0,1, 1,1,0, "R2");
    step(0,0, 0,0,1, "R2");
    // R2 event during clearing cycle
    step(1,0, 1,0,0, "R2");
    step(0,1, 1,1,0, "R2");
    step(1,0, 1,0,0, "R2");
    step(0,1, 1,1,0, "R2");
    step(0,0, 0,0,1, "R2");

    // R5 feedback leads
    step(0,1, 0,1,0, "R5");
    step(0,0, 0,1,0, "R5");
    step(1,0, 1,1,0, "R5");
    step(0,0, 0,0,1, "R5");

    // R4 coincident
    step(1,1, 1,1,0, "R4");
    step(0,0, 0,0,1, "R4");
    step(1,1, 1,1,0, "R4");
    step(0,0, 0,0,1, "R6");

    // R3 inverted polarity
    c_pol = 1'b0;
    step(1,0, 0,1,0, "R3");
    step(0,1, 1,1,0, "R3");
    step(0,0, 0,0,1, "R3");
    step(0,1, 1,0,0, "R3");
    step(1,0, 1,1,0, "R3");
    step(0,0, 0,0,1, "R3");
    c_pol = 1'b1;

    // R7 forced tri-state
    c_tri = 1'b1;
    step(1,0, 0,0,1, "R7");
    step(0,0, 0,0,1, "R7");
    c_tri = 1'b0;
    step(0,0, 0,0,1, "R7");
    step(0,1, 0,1,0, "R7");
    step(1,0, 1,1,0, "R7");
    step(0,0, 0,0,1, "R7");

    // R8 test routing
    c_test = 1'b1; c_tri = 1'b1; c_rdiv = 1'b1; c_fdiv = 1'b0; c_pol = 1'b0;
    e_ten = 1'b1; e_tlvl = 1'b1;
    step(1,0, 0,0,0, "R8");
    c_pol = 1'b1; e_tlvl = 1'b0;
    step(0,0, 0,0,0, "R8");
    c_fdiv = 1'b1; e_tlvl = 1'b1;
    step(0,1, 0,0,0, "R8");
    c_tri = 1'b0; e_ten = 1'b0; e_tlvl = 1'b0;
    step(0,0, 0,0,1, "R8");
    c_test = 1'b0; c_rdiv = 1'b0; c_fdiv = 1'b0;
    step(0,0, 0,0,1, "R8");

    // R9 counter reset, R13 events dropped
    c_crst = 1'b1; e_hold = 1'b1;
    step(1,0, 0,0,1, "R9");
    step(0,1, 0,0,1, "R13");
    c_crst = 1'b0; e_hold = 1'b0;
    step(0,0, 0,0,1, "R13");
    step(0,0, 0,0,1, "R13");

    // R10 synchronous power-down, idle
    c_pd = 1'b1; e_hold = 1'b1; e_pd = 1'b1;
    step(0,0, 0,0,1, "R10");
    c_pd = 1'b0; e_hold = 1'b0; e_pd = 1'b0;
    step(0,0, 0,0,1, "R10");

    // R10 synchronous power-down deferred by open pulse
    step(1,0, 1,0,0, "R10");
    c_pd = 1'b1;
    step(0,0, 1,0,0, "R10");
    step(0,1, 1,1,0, "R10");
    e_hold = 1'b1; e_pd = 1'b1;
    step(0,0, 0,0,1, "R10");
    step(1,0, 0,0,1, "R13");
    c_pd = 1'b0; e_hold = 1'b0; e_pd = 1'b0;
    step(0,0, 0,0,1, "R13");
    step(0,0, 0,0,1, "R13");

    // R11 asynchronous power-down mid-pulse
    step(1,0, 1,0,0, "R11");
    c_crst = 1'b1; c_pd = 1'b1; e_hold = 1'b1; e_pd = 1'b1;
    step(0,0, 0,0,1, "R11");
    step(0,1, 0,0,1, "R11");
    c_crst = 1'b0; c_pd = 1'b0; e_hold = 1'b0; e_pd = 1'b0;
    step(0,0, 0,0,1, "R13");
    step(0,0, 0,0,1, "R13");

    // R12 chip enable low
    step(1,0, 1,0,0, "R12");
    c_ce = 1'b0; e_hold = 1'b1; e_pd = 1'b1;
    step(0,0, 0,0,1, "R12");
    c_test = 1'b1; c_tri = 1'b1; c_fdiv = 1'b1;
    step(0,0, 0,0,1, "R12");
    c_test = 1'b0; c_tri = 1'b0; c_fdiv = 1'b0;
    c_ce = 1'b1; e_hold = 1'b0; e_pd = 1'b0;
    step(0,0, 0,0,1, "R12");
    step(0,0, 0,0,1, "R13");
    step(1,1, 1,1,0, "R4");
    step(0,0, 0,0,1, "R4");

    wait (q.size() == 0);
    @(posedge clk);
    #3;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule